// File: doc/BRIEF.md
# Isolated Digital I/O Port with Change-of-State Interrupt

This block is a byte-wide, register-mapped digital I/O port. It has sixteen latched drive outputs and sixteen sampled inputs, and it sits on a simple 8-bit bus with a 3-bit address and separate read and write strobes. Each input is brought into the clock domain by a synchronizer. An optional debounce filter can be placed in the input path. A change of either polarity on any accepted input can raise a level interrupt.

Several addresses act on the strobe itself rather than on the data. A read at the interrupt-control address arms the interrupt, and any write there disarms it. A read at the filter-control address turns debouncing on, and any write there turns it off. Any write to the low input address acknowledges a pending interrupt. Software finds an interrupt from this port by reading the status byte. The port owns the interrupt when the pending bit is set and at least one of the two byte-change flags is set. The block runs in one clock domain and uses a synchronous, active-high reset.

Top module: `iso_io_port`

## Requirements
- R1: After reset the outputs are all zero, irq is low, the status byte reads 0x00, interrupts are disarmed and filtering is off.
- R2: A write at address 0 loads outputs 7:0 and a write at address 4 loads outputs 15:8. Reading either address returns the value currently held in that latch.
- R3: With filtering off, a level change on an input pin shows in the input byte at address 1 (inputs 7:0) or address 5 (inputs 15:8) three clock edges after the pin changes.
- R4: A read strobe at address 2 arms interrupt generation. A write strobe at address 2 disarms it, whatever the write data.
- R5: A read strobe at address 3 turns the input filter on for all sixteen inputs. A write strobe at address 3 turns it off, whatever the write data.
- R6: With filtering on, a synchronized input level that differs from the accepted level is taken only after it has held for 4 consecutive cycles with filtTick high. A shorter pulse is dropped. Cycles with filtTick low do not advance the count.
- R7: When armed, both rising and falling changes of the accepted inputs are latched. Status bit 0 flags a change on inputs 7:0 and bit 1 flags a change on inputs 15:8; both flags are sticky. Bit 2 is set while either flag is set. Bits 7:3 read as zero.
- R8: Any write at address 1 clears both change flags, whatever the write data. A change that is latched on the same clock edge wins over the clear.
- R9: Input changes that occur while interrupts are disarmed are not latched.
- R10: Writes at addresses 5 and 6 have no effect on the outputs, the output latches or the status byte.
- R11: irq is high exactly while interrupts are armed and status bit 2 is set. Disarming lowers irq but leaves the status byte unchanged.
- R12: Reads at addresses 2, 3 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the address |
| filtTick | input | 1 | Clock enable for the debounce count |
| inPins | input | 16 | Raw input levels |
| outPins | output | 16 | Output latch levels |
| irq | output | 1 | Level interrupt request |

## Verification
Read data is combinational, so the bench samples it just before the edge that completes the read. The side effect of that read (arming the interrupt or turning on the filter) takes effect on the same edge and appears at the next falling edge. With filtering off, a pin change reaches the input byte and the status byte three edges after it is driven. With filtering on and filtTick held high, it takes six edges. The bench checks irq one edge before each of these points and again at the point itself, so an early or a late arrival is caught. The table of vectors and the directed tests drive every input at a falling edge and sample at a falling edge, counting whole edges from the stimulus.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;
  localparam int NUM_BYTES = 2;
  localparam int NUM_BITS  = NUM_BYTES * 8;

  localparam logic [2:0] ADDR_OUT_LO = 3'd0;
  localparam logic [2:0] ADDR_IN_LO  = 3'd1;
  localparam logic [2:0] ADDR_IRQCTL = 3'd2;
  localparam logic [2:0] ADDR_FILT   = 3'd3;
  localparam logic [2:0] ADDR_OUT_HI = 3'd4;
  localparam logic [2:0] ADDR_IN_HI  = 3'd5;
  localparam logic [2:0] ADDR_STAT   = 3'd6;

  // strobes from control to datapath, each one cycle wide
  typedef struct packed {
    logic wrOutLo;
    logic wrOutHi;
    logic clrPend;
  } ioStrb_t;
endpackage

// File: rtl/iso_io_ctrl.sv
module iso_io_ctrl
  import iso_io_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  output ioStrb_t    strb,
  output logic       irqEn,
  output logic       filtEn
);
  logic irqOn, irqOff, filtOn, filtOff;

  always_comb begin
    strb.wrOutLo = busWrEn && (busAddr == ADDR_OUT_LO);
    strb.wrOutHi = busWrEn && (busAddr == ADDR_OUT_HI);
    strb.clrPend = busWrEn && (busAddr == ADDR_IN_LO);
    irqOn        = busRdEn && (busAddr == ADDR_IRQCTL);
    irqOff       = busWrEn && (busAddr == ADDR_IRQCTL);
    filtOn       = busRdEn && (busAddr == ADDR_FILT);
    filtOff      = busWrEn && (busAddr == ADDR_FILT);
  end

  // a write wins over a read that arrives in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irqEn  <= 1'b0;
      filtEn <= 1'b0;
    end else begin
      if (irqOff)      irqEn <= 1'b0;
      else if (irqOn)  irqEn <= 1'b1;
      if (filtOff)     filtEn <= 1'b0;
      else if (filtOn) filtEn <= 1'b1;
    end
  end

  a_r4_read_arms: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && !busWrEn && busAddr == ADDR_IRQCTL) |=> irqEn);
  a_r4_write_disarms: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == ADDR_IRQCTL) |=> !irqEn);
  a_r5_read_filters: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && !busWrEn && busAddr == ADDR_FILT) |=> filtEn);
  a_r5_write_unfilters: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && busAddr == ADDR_FILT) |=> !filtEn);
endmodule

// File: rtl/iso_io_datapath.sv
module iso_io_datapath
  import iso_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_HOLD   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  ioStrb_t             strb,
  input  logic                irqEn,
  input  logic                filtEn,
  input  logic                filtTick,
  input  logic [2:0]          busAddr,
  input  logic [7:0]          busWrData,
  output logic [7:0]          busRdData,
  input  logic [NUM_BITS-1:0] inPins,
  output logic [NUM_BITS-1:0] outPins,
  output logic                irq
);
  localparam int CNT_W = (FILT_HOLD > 2) ? $clog2(FILT_HOLD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_HOLD - 1);

  logic [7:0]          outLo, outHi;
  logic [NUM_BITS-1:0] accVal, accNext;
  logic                stLo, stHi, pend, chgLo, chgHi;

  // output latches
  always_ff @(posedge clk) begin
    if (rst) begin
      outLo <= '0;
      outHi <= '0;
    end else begin
      if (strb.wrOutLo) outLo <= busWrData;
      if (strb.wrOutHi) outHi <= busWrData;
    end
  end
  assign outPins = {outHi, outLo};

  // per-input synchronizer and debounce filter
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_in
    logic [SYNC_STAGES-1:0] chain;
    logic                   syncd, acc, accN;
    logic [CNT_W-1:0]       cnt, cntN;

    assign syncd = chain[SYNC_STAGES-1];

    always_comb begin
      accN = acc;
      cntN = cnt;
      if (!filtEn) begin
        accN = syncd;
        cntN = '0;
      end else if (syncd == acc) begin
        cntN = '0;
      end else if (filtTick) begin
        if (cnt == CNT_LAST) begin
          accN = syncd;
          cntN = '0;
        end else begin
          cntN = cnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        acc   <= 1'b0;
        cnt   <= '0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], inPins[i]};
        acc   <= accN;
        cnt   <= cntN;
      end
    end

    assign accVal[i]  = acc;
    assign accNext[i] = accN;
  end

  // change-of-state detection on the accepted levels
  assign chgLo = |(accNext[7:0] ^ accVal[7:0]);
  assign chgHi = |(accNext[15:8] ^ accVal[15:8]);

  // a change seen on the clearing edge is kept
  always_ff @(posedge clk) begin
    if (rst) begin
      stLo <= 1'b0;
      stHi <= 1'b0;
    end else begin
      if (strb.clrPend) begin
        stLo <= 1'b0;
        stHi <= 1'b0;
      end
      if (irqEn) begin
        if (chgLo) stLo <= 1'b1;
        if (chgHi) stHi <= 1'b1;
      end
    end
  end
  assign pend = stLo | stHi;
  assign irq  = irqEn & pend;

  always_comb begin
    unique case (busAddr)
      ADDR_OUT_LO: busRdData = outLo;
      ADDR_IN_LO:  busRdData = accVal[7:0];
      ADDR_OUT_HI: busRdData = outHi;
      ADDR_IN_HI:  busRdData = accVal[15:8];
      ADDR_STAT:   busRdData = {5'b0, pend, stHi, stLo};
      default:     busRdData = 8'h00;
    endcase
  end

  a_r2_low_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.wrOutLo |=> $stable(outPins[7:0]));
  a_r2_high_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.wrOutHi |=> $stable(outPins[15:8]));
  a_r6_no_tick_no_accept: assert property (@(posedge clk) disable iff (rst)
    (filtEn && !filtTick) |=> $stable(accVal));
  a_r9_disarmed_no_latch: assert property (@(posedge clk) disable iff (rst)
    (!irqEn && !pend) |=> !pend);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    (strb.clrPend && !(irqEn && (chgLo || chgHi))) |=> !pend);
endmodule

// File: rtl/iso_io_port.sv
module iso_io_port
  import iso_io_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_HOLD   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  busAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        filtTick,
  input  logic [15:0] inPins,
  output logic [15:0] outPins,
  output logic        irq
);
  ioStrb_t strb;
  logic    irqEn, filtEn;

  iso_io_ctrl u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strb(strb), .irqEn(irqEn), .filtEn(filtEn)
  );

  iso_io_datapath #(.SYNC_STAGES(SYNC_STAGES), .FILT_HOLD(FILT_HOLD)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .irqEn(irqEn), .filtEn(filtEn),
    .filtTick(filtTick), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .inPins(inPins), .outPins(outPins), .irq(irq)
  );
endmodule

// File: tb/iso_io_port_tb.sv
module iso_io_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        filtTick = 1'b1;
  logic [15:0] inPins = '0;
  logic [15:0] outPins;
  logic        irq;
  int          total = 0, bad = 0;
  logic [7:0]  rd;

  always #10 clk = ~clk;

  iso_io_port u_dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .filtTick(filtTick), .inPins(inPins), .outPins(outPins), .irq(irq)
  );

  // kind: 0 write, 1 read and compare, 2 drive pins and wait three edges
  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  addr;
    logic [7:0]  data;
    logic [15:0] pins;
    logic [7:0]  expRd;
    logic        expIrq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd1},  // R1 status clear
    '{2'd1, 3'd0, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd1},  // R1 outputs zero
    '{2'd0, 3'd0, 8'hA5, 16'h0000, 8'h00, 1'b0, 4'd2},  // R2
    '{2'd1, 3'd0, 8'h00, 16'h0000, 8'hA5, 1'b0, 4'd2},  // R2
    '{2'd0, 3'd4, 8'h3C, 16'h0000, 8'h00, 1'b0, 4'd2},  // R2
    '{2'd1, 3'd4, 8'h00, 16'h0000, 8'h3C, 1'b0, 4'd2},  // R2
    '{2'd2, 3'd0, 8'h00, 16'h0001, 8'h00, 1'b0, 4'd9},  // R9 disarmed edge
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd9},  // R9
    '{2'd1, 3'd1, 8'h00, 16'h0000, 8'h01, 1'b0, 4'd3},  // R3
    '{2'd1, 3'd2, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd4},  // R4 arm
    '{2'd2, 3'd0, 8'h00, 16'h0000, 8'h00, 1'b1, 4'd7},  // R7 falling
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h05, 1'b1, 4'd7},  // R7
    '{2'd0, 3'd1, 8'hFF, 16'h0000, 8'h00, 1'b0, 4'd8},  // R8 clear
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd8},  // R8
    '{2'd2, 3'd0, 8'h00, 16'h8000, 8'h00, 1'b1, 4'd7},  // R7 rising high
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h06, 1'b1, 4'd7},  // R7
    '{2'd1, 3'd5, 8'h00, 16'h0000, 8'h80, 1'b1, 4'd3},  // R3
    '{2'd0, 3'd5, 8'h00, 16'h0000, 8'h00, 1'b1, 4'd10}, // R10
    '{2'd0, 3'd6, 8'h00, 16'h0000, 8'h00, 1'b1, 4'd10}, // R10
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h06, 1'b1, 4'd10}, // R10
    '{2'd1, 3'd0, 8'h00, 16'h0000, 8'hA5, 1'b1, 4'd10}, // R10
    '{2'd1, 3'd4, 8'h00, 16'h0000, 8'h3C, 1'b1, 4'd10}, // R10
    '{2'd0, 3'd2, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd4},  // R4 disarm
    '{2'd1, 3'd6, 8'h00, 16'h0000, 8'h06, 1'b0, 4'd11}, // R11 kept
    '{2'd0, 3'd1, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd8},  // R8
    '{2'd1, 3'd7, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd12}, // R12
    '{2'd1, 3'd3, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd12}, // R12, filter on
    '{2'd1, 3'd2, 8'h00, 16'h0000, 8'h00, 1'b0, 4'd12}  // R12, arm
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitEdges(3);
    rst = 1'b0;
    check({15'b0, irq}, 16'h0, "R1 irq after reset");
    check(outPins, 16'h0, "R1 outputs after reset");

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].kind)
        2'd0: busWrite(VECS[k].addr, VECS[k].data);
        2'd1: begin
          busRead(VECS[k].addr, rd);
          check({8'h0, rd}, {8'h0, VECS[k].expRd}, $sformatf("R%0d row %0d read", VECS[k].req, k));
        end
        default: begin
          inPins = VECS[k].pins;
          waitEdges(3);
        end
      endcase
      check({15'b0, irq}, {15'b0, VECS[k].expIrq}, $sformatf("R%0d row %0d irq", VECS[k].req, k));
    end
    check(outPins, 16'h3CA5, "R2 output pins");

    // R6: a two-cycle glitch is dropped while filtering
    inPins = 16'h8001; waitEdges(2);
    inPins = 16'h8000; waitEdges(10);
    check({15'b0, irq}, 16'h0, "R6 glitch irq");
    busRead(3'd1, rd);
    check({8'h0, rd}, 16'h0000, "R6 glitch input byte");

    // R6: a held level is taken on the sixth edge
    inPins = 16'h8001; waitEdges(5);
    check({15'b0, irq}, 16'h0, "R6 before hold complete");
    waitEdges(1);
    check({15'b0, irq}, 16'h1, "R6 hold complete");
    busRead(3'd1, rd);
    check({8'h0, rd}, 16'h0001, "R6 accepted level");
    busWrite(3'd1, 8'h00);

    // R6: no ticks, no progress
    filtTick = 1'b0;
    inPins = 16'h8000; waitEdges(20);
    check({15'b0, irq}, 16'h0, "R6 stalled without ticks");
    filtTick = 1'b1; waitEdges(3);
    check({15'b0, irq}, 16'h0, "R6 three ticks");
    waitEdges(1);
    check({15'b0, irq}, 16'h1, "R6 fourth tick");
    busWrite(3'd1, 8'h00);

    // R5: write at address 3 turns the filter off
    busWrite(3'd3, 8'hFF);
    inPins = 16'h8001; waitEdges(3);
    check({15'b0, irq}, 16'h1, "R5 unfiltered timing");
    busWrite(3'd1, 8'h00);
    check({15'b0, irq}, 16'h0, "R8 clear after R5 test");

    // R8: change latched on the clearing edge wins
    inPins = 16'h8000; waitEdges(2);
    busWrite(3'd1, 8'h00);
    check({15'b0, irq}, 16'h1, "R8 change beats clear");
    busRead(3'd6, rd);
    check({8'h0, rd}, 16'h0005, "R8 status after race");

    // R1: reset returns to the idle state
    rst = 1'b1; waitEdges(2); rst = 1'b0;
    check(outPins, 16'h0, "R1 outputs after second reset");
    check({15'b0, irq}, 16'h0, "R1 irq after second reset");
    busRead(3'd6, rd);
    check({8'h0, rd}, 16'h0, "R1 status after second reset");
    inPins = 16'h0001; waitEdges(3);
    check({15'b0, irq}, 16'h0, "R1 disarmed after reset");
    busRead(3'd1, rd);
    check({8'h0, rd}, 16'h0001, "R1 filter off after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule